// File: doc/BRIEF.md
# Per-Bank Refresh Command Issuer for Low-Power SDRAM

This block decides when a refresh may go out to one low-power SDRAM rank and drives the refresh command onto the command/address pins. Two refresh kinds exist. A bank refresh carries no bank number. The device chooses the bank from a hidden counter that starts at bank 0 and steps by one after every bank refresh. An all-bank refresh refreshes every bank and returns that counter to bank 0. The issuer keeps its own copy of the counter, and issuing an all-bank refresh is the way to bring that copy back into line with the device.

A requester raises `ref_req` and chooses the kind with `ref_all`. It holds both until `ref_done` pulses.

- A bank refresh is sent when the bank under the pointer is idle and not still refreshing. The state of every other bank is ignored.
- An all-bank refresh waits until every bank is idle and none is busy.
- After issue, the refreshed bank, or every bank, is flagged busy for a refresh-cycle count taken from a parameter.
- A sliding record of issue times keeps the number of refreshes inside any burst window, 32 all-bank cycle times long, at or below a parameter limit.

Top module: `lp_refresh_issuer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `cmd_en`, `cmd_ca`, `ref_done` and `bank_busy` are all zero. The pointer starts at bank 0, so the first bank refresh after reset targets bank 0.
- R2: In a cycle that carries a refresh, `cmd_en` is 1 and `cmd_ca` is set as follows: bit 0 = 0, bit 1 = 0, bit 2 = 1, and bit 3 = 0 for a bank refresh or 1 for an all-bank refresh. In every other cycle `cmd_en` is 0 and `cmd_ca` is 4'b0000.
- R3: A bank refresh targets the pointer's bank. The pointer then steps by one, and from bank NUM_BANKS-1 it wraps to bank 0.
- R4: An all-bank refresh returns the pointer to bank 0.
- R5: A bank refresh is withheld while the target bank's `bank_idle` bit is 0 or its busy flag is set. The `bank_idle` bits of the other banks have no effect on it.
- R6: An all-bank refresh is withheld while any `bank_idle` bit is 0 or any busy flag is set. A bank becomes usable on the second edge after its busy flag rises for the last cycle; for example, with PB_CYC = 3, an all-bank request waiting on a bank refresh issued at edge E goes out at edge E+4.
- R7: After a bank refresh, only the target bank's busy flag rises, in the same cycle as the command, and it stays high for exactly PB_CYC cycles.
- R8: After an all-bank refresh, every busy flag rises in the same cycle as the command and stays high for exactly AB_CYC cycles.
- R9: `ref_done` is a one-cycle pulse in the cycle that carries the command. It is 0 whenever no request is served.
- R10: No window of WIN = WIN_MULT*AB_CYC consecutive edges carries more than BURST_MAX refreshes. A request stalled by this limit goes out exactly WIN edges after the oldest refresh in the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_idle | input | NUM_BANKS | One bit per bank; 1 = bank has no open row and may be refreshed |
| ref_req | input | 1 | Refresh wanted; held until `ref_done` |
| ref_all | input | 1 | Kind of refresh: 1 = all-bank, 0 = bank refresh |
| cmd_en | output | 1 | Command slot carries a refresh |
| cmd_ca | output | 4 | Command/address code of the refresh |
| bank_busy | output | NUM_BANKS | Bank is inside its refresh cycle time |
| ref_done | output | 1 | One-cycle pulse when the request is served |

## Verification
Two cases can land on the same edge, and each needs its own test.

The first case is an entry expiring from the burst window on the very edge a stalled request goes out. The bench provokes it by holding a bank-refresh request high while eight refreshes fill the window. It then checks that the ninth refresh appears exactly WIN edges after the first, and that it targets bank 0 after the pointer wrapped.

The second case is a busy flag clearing while an all-bank request is waiting on that bank. The bench switches a request to all-bank in the cycle right after a bank refresh. It checks that the all-bank command appears exactly PB_CYC+1 edges later.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

   localparam int CA_W = 4;

   // Refresh code: bits 1:0 low, bit 2 high, bit 3 picks the refresh kind.
   function automatic logic [CA_W-1:0] ref_code(input logic all_banks);
      return {all_banks, 1'b1, 1'b0, 1'b0};
   endfunction

endpackage

// File: rtl/lpr_bank_ptr.sv
module lpr_bank_ptr #(
   parameter int NUM_BANKS = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         step,
   input  logic                         clear,
   output logic [$clog2(NUM_BANKS)-1:0] ptr
);
   localparam int PTR_W = $clog2(NUM_BANKS);
   localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_BANKS - 1);

   generate
      if (NUM_BANKS < 2) begin : g_bad_banks
         $error("lpr_bank_ptr: NUM_BANKS must be at least 2");
      end
   endgenerate

   logic [PTR_W-1:0] ptr_next;

   generate
      if ((1 << PTR_W) == NUM_BANKS) begin : g_pow2
         assign ptr_next = ptr + 1'b1;
      end else begin : g_wrap
         assign ptr_next = (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ptr <= '0;
      else if (clear)  ptr <= '0;
      else if (step)   ptr <= ptr_next;
   end

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(step && !clear) && $past(ptr) == LAST) |-> ptr == '0); // R3
   AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(clear)) |-> ptr == '0); // R4
endmodule

// File: rtl/lpr_busy_timers.sv
module lpr_busy_timers #(
   parameter int NUM_BANKS = 8,
   parameter int PB_CYC    = 3,
   parameter int AB_CYC    = 5
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] load_one,
   input  logic                 load_all,
   output logic [NUM_BANKS-1:0] busy
);
   localparam int CNT_W = $clog2(AB_CYC + 1);

   generate
      if (PB_CYC < 1 || AB_CYC < PB_CYC) begin : g_bad_cyc
         $error("lpr_busy_timers: need 1 <= PB_CYC <= AB_CYC");
      end
   endgenerate

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic [CNT_W-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           cnt <= '0;
         else if (load_all)    cnt <= CNT_W'(AB_CYC);
         else if (load_one[b]) cnt <= CNT_W'(PB_CYC);
         else if (cnt != '0)   cnt <= cnt - 1'b1;
      end
      assign busy[b] = (cnt != '0);

      AST_BUSY_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
         (load_one[b] || load_all) |=> busy[b]); // R7
   end
endmodule

// File: rtl/lpr_burst_window.sv
module lpr_burst_window #(
   parameter int BURST_MAX = 8,
   parameter int WIN       = 160
) (
   input  logic clk,
   input  logic rst_n,
   input  logic issue,
   output logic room
);
   localparam int AGE_W = $clog2(WIN);
   localparam int CNT_W = $clog2(BURST_MAX + 1);
   localparam logic [AGE_W-1:0] AGE_END = AGE_W'(WIN - 1);

   generate
      if (BURST_MAX < 1 || WIN < 2 * BURST_MAX) begin : g_bad_win
         $error("lpr_burst_window: need BURST_MAX >= 1 and WIN >= 2*BURST_MAX");
      end
   endgenerate

   logic [BURST_MAX-1:0] valid;
   logic [BURST_MAX-1:0] active;
   logic [BURST_MAX-1:0] alloc_oh;
   logic [AGE_W-1:0]     age [BURST_MAX];
   logic [CNT_W-1:0]     used;

   // A slot whose age reached the last cycle no longer counts.
   always_comb begin
      for (int s = 0; s < BURST_MAX; s++) begin
         active[s] = valid[s] && (age[s] != AGE_END);
      end
   end

   always_comb begin
      logic found;
      found    = 1'b0;
      alloc_oh = '0;
      used     = '0;
      for (int s = 0; s < BURST_MAX; s++) begin
         if (active[s]) used = used + 1'b1;
         if (!active[s] && !found) begin
            alloc_oh[s] = 1'b1;
            found       = 1'b1;
         end
      end
   end

   assign room = (used < CNT_W'(BURST_MAX));

   for (genvar s = 0; s < BURST_MAX; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid[s] <= 1'b0;
            age[s]   <= '0;
         end else if (issue && alloc_oh[s]) begin
            valid[s] <= 1'b1;
            age[s]   <= '0;
         end else if (valid[s]) begin
            if (age[s] == AGE_END) valid[s] <= 1'b0;
            else                   age[s]   <= age[s] + 1'b1;
         end
      end
   end

   AST_WIN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(active) <= BURST_MAX); // R10
   AST_WIN_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(active) == BURST_MAX) |-> !issue); // R10
endmodule

// File: rtl/lp_refresh_issuer.sv
module lp_refresh_issuer
   import lpr_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int PB_CYC    = 3,
   parameter int AB_CYC    = 5,
   parameter int BURST_MAX = 8,
   parameter int WIN_MULT  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_BANKS-1:0] bank_idle,
   input  logic                 ref_req,
   input  logic                 ref_all,
   output logic                 cmd_en,
   output logic [CA_W-1:0]      cmd_ca,
   output logic [NUM_BANKS-1:0] bank_busy,
   output logic                 ref_done
);
   localparam int WIN   = WIN_MULT * AB_CYC;
   localparam int PTR_W = $clog2(NUM_BANKS);

   generate
      if (WIN_MULT < 1) begin : g_bad_mult
         $error("lp_refresh_issuer: WIN_MULT must be positive");
      end
   endgenerate

   logic [PTR_W-1:0]     ptr;
   logic [NUM_BANKS-1:0] tgt_oh;
   logic                 room;
   logic                 pb_ok, ab_ok;
   logic                 issue, issue_pb, issue_ab;

   assign tgt_oh   = NUM_BANKS'(1) << ptr;
   assign pb_ok    = |(tgt_oh & bank_idle & ~bank_busy);
   assign ab_ok    = (&bank_idle) && !(|bank_busy);
   assign issue    = ref_req && room && (ref_all ? ab_ok : pb_ok);
   assign issue_pb = issue && !ref_all;
   assign issue_ab = issue && ref_all;

   lpr_bank_ptr #(.NUM_BANKS(NUM_BANKS)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .step  (issue_pb),
      .clear (issue_ab),
      .ptr   (ptr)
   );

   lpr_busy_timers #(.NUM_BANKS(NUM_BANKS), .PB_CYC(PB_CYC), .AB_CYC(AB_CYC)) u_busy (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_one (issue_pb ? tgt_oh : '0),
      .load_all (issue_ab),
      .busy     (bank_busy)
   );

   lpr_burst_window #(.BURST_MAX(BURST_MAX), .WIN(WIN)) u_win (
      .clk   (clk),
      .rst_n (rst_n),
      .issue (issue),
      .room  (room)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_en   <= 1'b0;
         cmd_ca   <= '0;
         ref_done <= 1'b0;
      end else begin
         cmd_en   <= issue;
         cmd_ca   <= issue ? ref_code(ref_all) : '0;
         ref_done <= issue;
      end
   end

   AST_CA_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_en |-> (cmd_ca[2:0] == 3'b100)); // R2
   AST_CA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_en |-> (cmd_ca == '0)); // R2
   AST_PB_ONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en && !cmd_ca[3]) |-> $onehot(bank_busy & ~$past(bank_busy))); // R7
   AST_AB_ALL_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en && cmd_ca[3]) |-> (&bank_busy)); // R8
   AST_AB_NEED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_en && cmd_ca[3]) |-> ((&$past(bank_idle)) && !(|$past(bank_busy)))); // R6
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      ref_done |=> !ref_done || $past(ref_req)); // R9
endmodule

// File: tb/lp_refresh_issuer_bench.sv
module lp_refresh_issuer_bench;
   localparam int NB     = 8;
   localparam int PB     = 3;
   localparam int AB     = 5;
   localparam int BMAX   = 8;
   localparam int MULT   = 32;
   localparam int WIN    = MULT * AB;
   localparam int WDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NB-1:0] bank_idle = '1;
   logic          ref_req = 1'b0;
   logic          ref_all = 1'b0;
   logic          cmd_en;
   logic [3:0]    cmd_ca;
   logic [NB-1:0] bank_busy;
   logic          ref_done;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;
   int exp_ptr = 0;

   always #4 clk = ~clk;

   lp_refresh_issuer #(.NUM_BANKS(NB), .PB_CYC(PB), .AB_CYC(AB),
                       .BURST_MAX(BMAX), .WIN_MULT(MULT)) u_lp_refresh_issuer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bank_idle (bank_idle),
      .ref_req   (ref_req),
      .ref_all   (ref_all),
      .cmd_en    (cmd_en),
      .cmd_ca    (cmd_ca),
      .bank_busy (bank_busy),
      .ref_done  (ref_done)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == WDOG) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: act=%0d cycles exp=<%0d", cyc, WDOG);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   // Vector fields: {all, fire, idle[7:0]}
   localparam logic [9:0] VEC [0:7] = '{
      {1'b0, 1'b1, 8'hFF},   // bank 0
      {1'b0, 1'b1, 8'hFF},   // bank 1
      {1'b0, 1'b0, 8'hFB},   // target bank 2 not idle: withheld
      {1'b0, 1'b1, 8'h04},   // only bank 2 idle: still issues
      {1'b1, 1'b0, 8'h7F},   // all-bank with bank 7 open: withheld
      {1'b1, 1'b1, 8'hFF},   // all-bank, pointer back to 0
      {1'b0, 1'b1, 8'hFF},   // bank 0 again
      {1'b0, 1'b1, 8'h02}    // bank 1, others closed
   };

   task automatic run_vec(input logic all, input logic fire, input logic [NB-1:0] idle);
      logic          got;
      logic [NB-1:0] exp_busy;
      logic          held;
      int            len;
      string         kind;
      kind = all ? "R6/R8" : "R5/R7";
      @(negedge clk);
      ref_all   = all;
      bank_idle = idle;
      ref_req   = 1'b1;
      got = 1'b0;
      for (int k = 0; k < 40 && !got; k++) begin
         @(negedge clk);
         if (ref_done) got = 1'b1;
      end
      ref_req = 1'b0;
      if (fire) begin
         chk({kind, " R9 done seen"}, 32'(got), 32'd1);
         chk("R2 cmd_en", 32'(cmd_en), 32'd1);
         chk("R2 cmd_ca", 32'(cmd_ca), 32'({all, 3'b100}));
         exp_busy = all ? '1 : (NB'(1) << exp_ptr);
         chk(all ? "R4/R8 busy all" : "R3/R7 busy target", 32'(bank_busy), 32'(exp_busy));
         exp_ptr = all ? 0 : (exp_ptr + 1) % NB;
         len  = all ? AB : PB;
         held = 1'b1;
         @(negedge clk);
         chk("R9 single pulse", 32'({ref_done, cmd_en, |cmd_ca}), 32'd0);
         if (bank_busy !== exp_busy) held = 1'b0;
         for (int k = 2; k < len; k++) begin
            @(negedge clk);
            if (bank_busy !== exp_busy) held = 1'b0;
         end
         chk({kind, " busy held"}, 32'(held), 32'd1);
         @(negedge clk);
         chk({kind, " busy released"}, 32'(bank_busy), 32'd0);
      end else begin
         chk({kind, " withheld"}, 32'({got, cmd_en, |bank_busy}), 32'd0);
      end
      bank_idle = '1;
      ref_all   = 1'b0;
   endtask

   initial begin
      int t_pb;
      int t_ab;
      int ndone;
      int tim [0:8];
      logic [NB-1:0] busy9;
      logic seq_ok;

      // R1: reset state, request held during reset
      ref_req = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 reset outputs", 32'({cmd_en, cmd_ca, ref_done, bank_busy}), 32'd0);
      ref_req = 1'b0;
      rst_n   = 1'b1;
      @(negedge clk);
      chk("R1 first cycle quiet", 32'({cmd_en, cmd_ca, ref_done, bank_busy}), 32'd0);

      // R9: no request, no command
      repeat (5) @(negedge clk);
      chk("R9 idle no done", 32'({ref_done, cmd_en}), 32'd0);

      // Table walk (R1 first target is bank 0)
      for (int v = 0; v < 8; v++) begin
         run_vec(VEC[v][9], VEC[v][8], VEC[v][7:0]);
      end

      // R6: all-bank waits on a busy bank
      repeat (WIN + 4) @(negedge clk);
      ref_all = 1'b0;
      ref_req = 1'b1;
      t_pb = -1;
      for (int k = 0; k < 40 && t_pb < 0; k++) begin
         @(negedge clk);
         if (ref_done) t_pb = cyc;
      end
      exp_ptr = (exp_ptr + 1) % NB;
      ref_all = 1'b1;
      t_ab = -1;
      for (int k = 0; k < 40 && t_ab < 0; k++) begin
         @(negedge clk);
         if (ref_done) t_ab = cyc;
      end
      ref_req = 1'b0;
      ref_all = 1'b0;
      exp_ptr = 0;
      chk("R6 all-bank after busy clears", 32'(t_ab - t_pb), 32'(PB + 1));
      chk("R8 all busy", 32'(bank_busy), 32'hFF);

      // R10 + R3 wrap: nine bank refreshes with the request held high
      repeat (WIN + 4) @(negedge clk);
      ref_req = 1'b1;
      ndone   = 0;
      busy9   = '0;
      for (int k = 0; k < 400 && ndone < 9; k++) begin
         @(negedge clk);
         if (ref_done) begin
            tim[ndone] = cyc;
            if (ndone == 8) begin
               busy9   = bank_busy;
               ref_req = 1'b0;
            end
            ndone = ndone + 1;
         end
      end
      ref_req = 1'b0;
      chk("R10 nine served", 32'(ndone), 32'd9);
      seq_ok = 1'b1;
      for (int i = 1; i < 8; i++) if (tim[i] != tim[0] + i) seq_ok = 1'b0;
      chk("R10 eight back to back", 32'(seq_ok), 32'd1);
      chk("R10 ninth waits full window", 32'(tim[8] - tim[0]), 32'(WIN));
      chk("R3 wrap to bank 0", 32'(busy9), 32'h01);

      repeat (4) @(negedge clk);
      chk("R9 quiet after burst", 32'({ref_done, cmd_en}), 32'd0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule